// File: doc/BRIEF.md
# GPIO Port Controller with Flash and Sensor Pin Control

This block is a word-addressed register file that controls two general-purpose ports, A and D. Each port has three registers: a stored output value, an output-enable mask and a read-only input view. The stored values and masks drive the pad outputs directly. Software reaches the registers through a simple strobe bus with a write-enable, a byte address and 32-bit data.

Some port bits have a fixed meaning. On port A, three output bits drive the address-latch, command-latch and chip-enable lines of a NAND flash. The flash ready pin comes back on bit 7 of port A's input view. On port D, bit 1 of the output value is the clock of a serial sensor and bit 4 is the data sent to it. The sensor's serial output comes back on bit 4 of port D's input view. Software clocks the sensor by hand. Any write that flips the clock bit raises a one-cycle edge event.

The window spans 0x5C bytes, which is 23 words. Every word except the two input views is plain storage.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all stored words, pad outputs, flash lines, sensor lines, `sens_edge` and `bus_rdata` become zero.
- R2: The word index is the byte address shifted right by two. An access whose address has bits [1:0] nonzero, or whose address is 0x5C or above, is ignored: a write changes nothing and a read returns 0.
- R3: Every word in the window except the input views (byte 0x04 and byte 0x44) reads back the last value written to it. `bus_rdata` updates on the clock edge that samples a read strobe.
- R4: Writes to the input views at byte 0x04 and byte 0x44 have no effect on any register or pin.
- R5: A read of byte 0x04 returns (port A output at byte 0x00 AND port A enable at byte 0x08) OR (`nand_rdy` placed at bit 7).
- R6: A read of byte 0x44 returns (port D output at byte 0x40 AND port D enable at byte 0x48) OR (`sens_sdo` placed at bit 4).
- R7: After a write to byte 0x00, `nand_ale` equals data bit 6, `nand_cle` equals bit 5 and `nand_ce` equals bit 4. These lines ignore the enable mask.
- R8: After a write to byte 0x40, `sens_clk` equals data bit 1 and `sens_mosi` equals data bit 4.
- R9: `sens_edge` pulses high for exactly one cycle after a write to byte 0x40 whose bit 1 differs from the stored bit 1. A write that leaves bit 1 unchanged gives no pulse.
- R10: `pa_dout`, `pa_oe`, `pd_dout` and `pd_oe` show the stored words at bytes 0x00, 0x08, 0x40 and 0x48 from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| nand_rdy | input | 1 | Flash ready pin |
| sens_sdo | input | 1 | Sensor serial output |
| nand_ale | output | 1 | Flash address-latch enable |
| nand_cle | output | 1 | Flash command-latch enable |
| nand_ce | output | 1 | Flash chip enable |
| sens_clk | output | 1 | Sensor clock level |
| sens_mosi | output | 1 | Data to the sensor |
| sens_edge | output | 1 | One-cycle pulse on a sensor clock change |
| pa_dout | output | 32 | Port A output value |
| pa_oe | output | 32 | Port A output enable |
| pd_dout | output | 32 | Port D output value |
| pd_oe | output | 32 | Port D output enable |

## Verification
Several behaviours are checked on every cycle:
- ignored accesses, that is misaligned addresses, addresses outside the window and writes to the input views;
- the masked-and-merged value returned by a read of either input view;
- the mapping of written bits onto the flash and sensor lines;
- the rule that `sens_clk` changes exactly when `sens_edge` pulses.

Other behaviours only the bench scenarios can show: the reset state, the storage words reading back across the whole window including the last word, and the sequence of sensor clock toggles with and without a level change.

// File: rtl/gpio_port_pkg.sv
// Package: shared register indices for the GPIO port controller.
// Assumes a word-addressed window in which the six port registers sit at
// fixed word indices; every other word in the window is plain storage.
package gpio_port_pkg;

    localparam int IDX_PA_OUT = 0;
    localparam int IDX_PA_IN  = 1;
    localparam int IDX_PA_OE  = 2;
    localparam int IDX_PD_OUT = 16;
    localparam int IDX_PD_IN  = 17;
    localparam int IDX_PD_OE  = 18;

    // True for the read-only input-view words, which hold no storage.
    function automatic logic is_input_word(int w);
        return (w == IDX_PA_IN) || (w == IDX_PD_IN);
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
// Module: turns a byte address into a word index and a validity flag.
// Assumes only whole-word accesses are legal: an address with low bits set,
// or one past the last word of the window, is flagged invalid.
module gpio_addr_decode #(
    parameter int ADDR_W = 8,
    parameter int NWORDS = 23,
    parameter int IDX_W  = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              valid_o
);

    logic [ADDR_W-3:0] word_addr;

    // Split the byte address into its word part and check the bounds.
    always_comb begin
        word_addr = addr_i[ADDR_W-1:2];
        idx_o     = word_addr[IDX_W-1:0];
        valid_o   = (addr_i[1:0] == 2'b00) && (int'(word_addr) < NWORDS);
    end

endmodule

// File: rtl/gpio_reg_bank.sv
// Module: the storage words of the register window.
// Assumes one write per cycle. The input-view words hold no flops and
// read as zero here; the read mux builds their value instead.
module gpio_reg_bank
    import gpio_port_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NWORDS = 23,
    parameter int IDX_W  = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [IDX_W-1:0]               wr_idx_i,
    input  logic [DATA_W-1:0]              wr_data_i,
    output logic [NWORDS-1:0][DATA_W-1:0]  words_o
);

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        if (is_input_word(w)) begin : g_ro
            assign words_o[w] = '0;
        end else begin : g_rw
            logic [DATA_W-1:0] q;
            // Capture write data when this word is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en_i && (wr_idx_i == IDX_W'(w))) begin
                    q <= wr_data_i;
                end
            end
            assign words_o[w] = q;
        end
    end

endmodule

// File: rtl/gpio_clk_edge.sv
// Module: raises a one-cycle event when a write changes the sensor clock bit.
// Assumes the caller passes the write strobe for the port D output word,
// the clock bit being written and the clock bit currently stored.
module gpio_clk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic new_level_i,
    input  logic old_level_i,
    output logic edge_o
);

    // Pulse when the written clock level differs from the stored one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_o <= 1'b0;
        end else begin
            edge_o <= wr_i && (new_level_i != old_level_i);
        end
    end

endmodule

// File: rtl/gpio_read_mux.sv
// Module: builds the value returned for a read of any word.
// Assumes input views combine the enabled outputs with one external pin each.
// Storage words return their content, and invalid addresses return zero.
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NWORDS  = 23,
    parameter int IDX_W   = 5,
    parameter int RDY_BIT = 7,
    parameter int SDI_BIT = 4
) (
    input  logic [NWORDS-1:0][DATA_W-1:0] words_i,
    input  logic [IDX_W-1:0]              idx_i,
    input  logic                          valid_i,
    input  logic                          nand_rdy_i,
    input  logic                          sens_sdi_i,
    output logic [DATA_W-1:0]             value_o
);

    logic [DATA_W-1:0] pa_view;
    logic [DATA_W-1:0] pd_view;

    // Enabled outputs merged with the external pin of each port.
    always_comb begin
        pa_view          = words_i[IDX_PA_OUT] & words_i[IDX_PA_OE];
        pa_view[RDY_BIT] = pa_view[RDY_BIT] | nand_rdy_i;
        pd_view          = words_i[IDX_PD_OUT] & words_i[IDX_PD_OE];
        pd_view[SDI_BIT] = pd_view[SDI_BIT] | sens_sdi_i;
    end

    // Select the returned word from the decoded index.
    always_comb begin
        value_o = '0;
        if (valid_i) begin
            if (idx_i == IDX_W'(IDX_PA_IN)) begin
                value_o = pa_view;
            end else if (idx_i == IDX_W'(IDX_PD_IN)) begin
                value_o = pd_view;
            end else begin
                value_o = words_i[idx_i];
            end
        end
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
// Module: top of the GPIO port controller.
// Decodes strobe accesses into a word window. Drives the port pads, the
// flash control lines and the bit-banged sensor lines from the stored
// words, and returns the merged input views on reads.
// Assumes a single-cycle strobe; read data is registered and valid the
// cycle after the strobe.
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 8,
    parameter int WINDOW_BYTES = 92,
    parameter int RDY_BIT      = 7,
    parameter int ALE_BIT      = 6,
    parameter int CLE_BIT      = 5,
    parameter int CE_BIT       = 4,
    parameter int SCLK_BIT     = 1,
    parameter int SDO_BIT      = 4,
    parameter int SDI_BIT      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              nand_rdy,
    input  logic              sens_sdo,
    output logic              nand_ale,
    output logic              nand_cle,
    output logic              nand_ce,
    output logic              sens_clk,
    output logic              sens_mosi,
    output logic              sens_edge,
    output logic [DATA_W-1:0] pa_dout,
    output logic [DATA_W-1:0] pa_oe,
    output logic [DATA_W-1:0] pd_dout,
    output logic [DATA_W-1:0] pd_oe
);

    localparam int NWORDS = WINDOW_BYTES / 4;
    localparam int IDX_W  = $clog2(NWORDS);

    logic [IDX_W-1:0]              word_idx;
    logic                          addr_ok;
    logic                          wr_en;
    logic                          rd_en;
    logic                          wr_pd_out;
    logic [NWORDS-1:0][DATA_W-1:0] words;
    logic [DATA_W-1:0]             rd_value;

    gpio_addr_decode #(
        .ADDR_W (ADDR_W),
        .NWORDS (NWORDS),
        .IDX_W  (IDX_W)
    ) u_dec (
        .addr_i  (bus_addr),
        .idx_o   (word_idx),
        .valid_o (addr_ok)
    );

    // Qualify the strobe into write and read enables.
    always_comb begin
        wr_en     = bus_sel && bus_we && addr_ok;
        rd_en     = bus_sel && !bus_we;
        wr_pd_out = wr_en && (word_idx == IDX_W'(IDX_PD_OUT));
    end

    gpio_reg_bank #(
        .DATA_W (DATA_W),
        .NWORDS (NWORDS),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (word_idx),
        .wr_data_i (bus_wdata),
        .words_o   (words)
    );

    gpio_clk_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (wr_pd_out),
        .new_level_i (bus_wdata[SCLK_BIT]),
        .old_level_i (words[IDX_PD_OUT][SCLK_BIT]),
        .edge_o      (sens_edge)
    );

    gpio_read_mux #(
        .DATA_W  (DATA_W),
        .NWORDS  (NWORDS),
        .IDX_W   (IDX_W),
        .RDY_BIT (RDY_BIT),
        .SDI_BIT (SDI_BIT)
    ) u_rmux (
        .words_i    (words),
        .idx_i      (word_idx),
        .valid_i    (addr_ok),
        .nand_rdy_i (nand_rdy),
        .sens_sdi_i (sens_sdo),
        .value_o    (rd_value)
    );

    // Register read data on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            bus_rdata <= rd_value;
        end
    end

    // Map the stored words onto pads and device control lines.
    always_comb begin
        pa_dout   = words[IDX_PA_OUT];
        pa_oe     = words[IDX_PA_OE];
        pd_dout   = words[IDX_PD_OUT];
        pd_oe     = words[IDX_PD_OE];
        nand_ale  = words[IDX_PA_OUT][ALE_BIT];
        nand_cle  = words[IDX_PA_OUT][CLE_BIT];
        nand_ce   = words[IDX_PA_OUT][CE_BIT];
        sens_clk  = words[IDX_PD_OUT][SCLK_BIT];
        sens_mosi = words[IDX_PD_OUT][SDO_BIT];
    end

endmodule

// File: rtl/gpio_port_ctrl_checks.sv
// Module: property checker for the GPIO port controller, bound to the top.
// Assumes the default parameters and byte layout of the top module.
module gpio_port_ctrl_checks #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              nand_rdy,
    input logic              sens_sdo,
    input logic              nand_ale,
    input logic              nand_cle,
    input logic              nand_ce,
    input logic              sens_clk,
    input logic              sens_mosi,
    input logic              sens_edge,
    input logic [DATA_W-1:0] pa_dout,
    input logic [DATA_W-1:0] pa_oe,
    input logic [DATA_W-1:0] pd_dout,
    input logic [DATA_W-1:0] pd_oe
);

    logic bad_addr;
    logic pins_quiet;

    // Flag accesses the block must ignore.
    always_comb begin
        bad_addr   = (bus_addr[1:0] != 2'b00) || (int'(bus_addr) >= 92);
        pins_quiet = 1'b1;
    end

    p_bad_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_we && bad_addr |=>
            $stable(pa_dout) && $stable(pa_oe) && $stable(pd_dout) && $stable(pd_oe));

    p_bad_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_we && bad_addr |=> bus_rdata == '0);

    p_input_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_we && (bus_addr == 8'h04 || bus_addr == 8'h44) |=>
            $stable(pa_dout) && $stable(pa_oe) && $stable(pd_dout) && $stable(pd_oe) && pins_quiet);

    p_pa_view_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_we && bus_addr == 8'h04 |=>
            bus_rdata == (($past(pa_dout) & $past(pa_oe)) | (DATA_W'($past(nand_rdy)) << 7)));

    p_pd_view_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_we && bus_addr == 8'h44 |=>
            bus_rdata == (($past(pd_dout) & $past(pd_oe)) | (DATA_W'($past(sens_sdo)) << 4)));

    p_flash_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_we && bus_addr == 8'h00 |=>
            nand_ale == $past(bus_wdata[6]) && nand_cle == $past(bus_wdata[5]) &&
            nand_ce == $past(bus_wdata[4]));

    p_sensor_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_we && bus_addr == 8'h40 |=>
            sens_clk == $past(bus_wdata[1]) && sens_mosi == $past(bus_wdata[4]));

    p_edge_changes_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && sens_edge |-> sens_clk != $past(sens_clk));

    p_no_edge_clk_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !sens_edge |-> $stable(sens_clk));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_checks u_checks (.*);

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        nand_rdy = 1'b0;
    logic        sens_sdo = 1'b0;
    logic        nand_ale, nand_cle, nand_ce;
    logic        sens_clk, sens_mosi, sens_edge;
    logic [31:0] pa_dout, pa_oe, pd_dout, pd_oe;

    int n_total = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    gpio_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nand_rdy(nand_rdy), .sens_sdo(sens_sdo),
        .nand_ale(nand_ale), .nand_cle(nand_cle), .nand_ce(nand_ce),
        .sens_clk(sens_clk), .sens_mosi(sens_mosi), .sens_edge(sens_edge),
        .pa_dout(pa_dout), .pa_oe(pa_oe), .pd_dout(pd_dout), .pd_oe(pd_oe)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic        rdy;
        logic        sdo;
        logic [31:0] expv;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 8'h00, 32'h0000_00F0, 1'b0, 1'b0, 32'h0,          8'd3},  // R3 set A out
        '{1'b1, 8'h08, 32'h0000_0030, 1'b0, 1'b0, 32'h0,          8'd3},  // R3 set A enable
        '{1'b0, 8'h00, 32'h0,         1'b0, 1'b0, 32'h0000_00F0,  8'd3},  // R3
        '{1'b0, 8'h08, 32'h0,         1'b0, 1'b0, 32'h0000_0030,  8'd3},  // R3
        '{1'b0, 8'h04, 32'h0,         1'b0, 1'b0, 32'h0000_0030,  8'd5},  // R5 ready low
        '{1'b0, 8'h04, 32'h0,         1'b1, 1'b0, 32'h0000_00B0,  8'd5},  // R5 ready high
        '{1'b1, 8'h04, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0,          8'd4},  // R4 write to view
        '{1'b0, 8'h00, 32'h0,         1'b0, 1'b0, 32'h0000_00F0,  8'd4},  // R4
        '{1'b0, 8'h04, 32'h0,         1'b0, 1'b0, 32'h0000_0030,  8'd4},  // R4
        '{1'b1, 8'h40, 32'h1234_5612, 1'b0, 1'b0, 32'h0,          8'd6},  // R6 set D out
        '{1'b1, 8'h48, 32'h0000_FF00, 1'b0, 1'b0, 32'h0,          8'd6},  // R6 set D enable
        '{1'b0, 8'h44, 32'h0,         1'b0, 1'b0, 32'h0000_5600,  8'd6},  // R6 sdo low
        '{1'b0, 8'h44, 32'h0,         1'b0, 1'b1, 32'h0000_5610,  8'd6},  // R6 sdo high
        '{1'b1, 8'h44, 32'h0000_0000, 1'b0, 1'b0, 32'h0,          8'd4},  // R4 write to D view
        '{1'b0, 8'h40, 32'h0,         1'b0, 1'b0, 32'h1234_5612,  8'd4},  // R4
        '{1'b1, 8'h14, 32'hDEAD_BEEF, 1'b0, 1'b0, 32'h0,          8'd3},  // R3 plain word
        '{1'b0, 8'h14, 32'h0,         1'b0, 1'b0, 32'hDEAD_BEEF,  8'd3},  // R3
        '{1'b1, 8'h58, 32'hCAFE_F00D, 1'b0, 1'b0, 32'h0,          8'd3},  // R3 last word
        '{1'b0, 8'h58, 32'h0,         1'b0, 1'b0, 32'hCAFE_F00D,  8'd3},  // R3
        '{1'b0, 8'h5C, 32'h0,         1'b0, 1'b0, 32'h0,          8'd2},  // R2 past window
        '{1'b1, 8'h02, 32'h0000_0000, 1'b0, 1'b0, 32'h0,          8'd2},  // R2 misaligned write
        '{1'b0, 8'h00, 32'h0,         1'b0, 1'b0, 32'h0000_00F0,  8'd2}   // R2 A out kept
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_total++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, expv);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check_all_zero(input string req);
        check(req, pa_dout, 32'h0);
        check(req, pa_oe, 32'h0);
        check(req, pd_dout, 32'h0);
        check(req, pd_oe, 32'h0);
        check(req, {26'h0, nand_ale, nand_cle, nand_ce, sens_clk, sens_mosi, sens_edge}, 32'h0);
        check(req, bus_rdata, 32'h0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the pins and the read port
        check_all_zero("R1");
        bus_read(8'h04, rd);
        check("R1", rd, 32'h0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            nand_rdy = VEC[i].rdy;
            sens_sdo = VEC[i].sdo;
            if (VEC[i].wr) begin
                bus_write(VEC[i].addr, VEC[i].data);
            end else begin
                bus_read(VEC[i].addr, rd);
                check($sformatf("R%0d vec %0d", VEC[i].req, i), rd, VEC[i].expv);
            end
        end
        nand_rdy = 1'b0;
        sens_sdo = 1'b0;

        // R2: misaligned read returns zero
        bus_read(8'h01, rd);
        check("R2 misaligned read", rd, 32'h0);

        // R10: pads follow stored words
        check("R10 pa_dout", pa_dout, 32'h0000_00F0);
        check("R10 pa_oe", pa_oe, 32'h0000_0030);
        check("R10 pd_dout", pd_dout, 32'h1234_5612);
        check("R10 pd_oe", pd_oe, 32'h0000_FF00);

        // R7: each flash line alone
        bus_write(8'h00, 32'h0000_0040);
        check("R7 ale only", {29'h0, nand_ale, nand_cle, nand_ce}, 32'h4);
        bus_write(8'h00, 32'h0000_0020);
        check("R7 cle only", {29'h0, nand_ale, nand_cle, nand_ce}, 32'h2);
        bus_write(8'h00, 32'h0000_0010);
        check("R7 ce only", {29'h0, nand_ale, nand_cle, nand_ce}, 32'h1);

        // R8 / R9: sensor clock toggling; pd_dout currently has bit1 = 1
        bus_write(8'h40, 32'h0000_0000);
        check("R9 falling edge pulse", {31'h0, sens_edge}, 32'h1);
        check("R8 clk low", {30'h0, sens_clk, sens_mosi}, 32'h0);
        @(negedge clk);
        check("R9 pulse one cycle", {31'h0, sens_edge}, 32'h0);
        bus_write(8'h40, 32'h0000_0002);
        check("R9 rising edge pulse", {31'h0, sens_edge}, 32'h1);
        check("R8 clk high", {30'h0, sens_clk, sens_mosi}, 32'h2);
        bus_write(8'h40, 32'h0000_0012);
        check("R9 no pulse when clk kept", {31'h0, sens_edge}, 32'h0);
        check("R8 data high", {30'h0, sens_clk, sens_mosi}, 32'h3);
        bus_write(8'h04, 32'h0000_0000);
        check("R4 no pulse from view write", {30'h0, sens_clk, sens_edge}, 32'h2);

        // R1: reset in mid run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all_zero("R1 mid-run");
        bus_read(8'h14, rd);
        check("R1 storage cleared", rd, 32'h0);

        finish_run();
    end

endmodule